// File: doc/BRIEF.md
# Extended planar VGA read path

This block serves CPU byte reads from the legacy graphics window of a VGA-compatible frame buffer while an extension mode is switched on. It turns the 20-bit bus address into a frame-buffer offset: a window select fixes which addresses are accepted and how many offset bits are kept, a pair of bank base registers relocates each 32 KiB half, and two extension controls can scale the banked offset by two or by four before a memory-size mask wraps it.

With the offset known, the block issues one read on an 8-byte memory port at byte address offset×4. The low four bytes load the four plane latches. When the extended-latch control is on, the high four bytes also load a second set of four latches. The byte returned to the CPU is either one plane latch chosen by a map select, or a colour-compare result built from all four planes. Both latch sets are brought out so that a write path beside this block can use them.

Top module: `vga_ext_read`

## Requirements
- R1: The block accepts requests only while `cfg_pix_vga` is 1 and at least one bit of `cfg_ext[4:1]` is 1. Otherwise `req_ready` is 0, no memory read is issued, no response is given and both latch sets keep their values.
- R2: Window select 1 accepts 0xA0000–0xAFFFF and keeps address bits 15:0. Select 2 accepts 0xB0000–0xB7FFF and select 3 accepts 0xB8000 and up; both keep bits 14:0. Select 0 accepts 0xA0000–0xBFFFF and keeps bits 15:0.
- R3: A request outside the selected window gets `rsp_valid` with `rsp_data` = 0xFF in the cycle after acceptance. It issues no memory read and leaves both latch sets unchanged.
- R4: The banked offset is the kept offset bits 14:0 plus `cfg_bank1` when kept bit 15 is 1, or plus `cfg_bank0` when it is 0, taken modulo 2^32.
- R5: If `cfg_ext[1]` is 1, the banked offset is doubled. Otherwise, if `cfg_ext[4]` and `cfg_ext[2]` are both 1, it is multiplied by four. The result is ANDed with `cfg_mem_mask` and the memory byte address is four times that value, modulo 2^32.
- R6: On a hit, byte k of `mem_rd_data` (bits 8k+7:8k, k = 0..3) is loaded into plane latch k, which is `plane_latch[8k+7:8k]`.
- R7: Bytes 4..7 of `mem_rd_data` load `ext_latch[31:0]` (byte 4+k into bits 8k+7:8k) only when `cfg_ext[3]` is 1. Otherwise `ext_latch` keeps its value.
- R8: With `cfg_read_mode` = 0, `rsp_data` is plane latch number `cfg_map_pick` after the load.
- R9: With `cfg_read_mode` = 1, each plane latch p is XORed with eight copies of `cfg_cmp_color[p]` and then ANDed with eight copies of `cfg_cmp_care[p]`. `rsp_data` is the bitwise inverse of the OR of the four results.
- R10: A hit is accepted when `req_valid` and `req_ready` are both 1. `mem_rd_en` is high for exactly the next cycle. The memory data is taken in the cycle after that, and `rsp_valid` is high for one cycle in the cycle that follows. `req_ready` stays 0 from acceptance until the response.
- R11: After reset, `rsp_valid` and `mem_rd_en` are 0, both latch sets are zero and `req_ready` follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pix_vga | input | 1 | Sequencer is in planar VGA pixel mode |
| cfg_ext | input | 4 | Extension controls, bits 4:1 (1: ×2 scale, 2 and 4: ×4 scale, 3: extended latches) |
| cfg_map_sel | input | 2 | Memory window select |
| cfg_bank0 | input | 32 | Bank base for the lower 32 KiB half |
| cfg_bank1 | input | 32 | Bank base for the upper 32 KiB half |
| cfg_mem_mask | input | 32 | Memory-size offset mask |
| cfg_read_mode | input | 1 | 0: plane select, 1: colour compare |
| cfg_map_pick | input | 2 | Plane returned in read mode 0 |
| cfg_cmp_color | input | 4 | Compare colour, one bit per plane |
| cfg_cmp_care | input | 4 | Compare enables, one bit per plane |
| req_valid | input | 1 | CPU read request |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 20 | CPU bus address |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 64 | Memory data, valid the cycle after the strobe |
| plane_latch | output | 32 | Four plane latches |
| ext_latch | output | 32 | Four extended latches |

## Verification
The assertions assume that the memory returns data exactly one cycle after `mem_rd_en` and that the configuration inputs do not change while a request is in flight. The extended-latch hold check also assumes `cfg_ext[3]` is steady across the capture cycle. The bench changes configuration only between reads, while the block is idle. Its memory model is a registered array that answers every strobe on the next clock edge with bytes computed from the address. Random masks are always a power of two minus one, so wrapping is exercised without ever dropping an in-range low bit.

// File: rtl/vga_xrd_pkg.sv
package vga_xrd_pkg;
    localparam int PLANES = 4;
    localparam int LANE_W = 8;
    localparam int LAT_W  = PLANES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_CAPTURE = 2'd2
    } xrd_state_t;
endpackage

// File: rtl/vga_xrd_window.sv
module vga_xrd_window #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        map_sel,
    input  logic [OFF_W-1:0]  bank0,
    input  logic [OFF_W-1:0]  bank1,
    input  logic              scale_x2,
    input  logic              scale_x4,
    input  logic [OFF_W-1:0]  mem_mask,
    output logic              hit,
    output logic [OFF_W-1:0]  byte_addr
);
    localparam logic [ADDR_W-1:0] LO_A0 = ADDR_W'(20'hA0000);
    localparam logic [ADDR_W-1:0] HI_AF = ADDR_W'(20'hAFFFF);
    localparam logic [ADDR_W-1:0] LO_B0 = ADDR_W'(20'hB0000);
    localparam logic [ADDR_W-1:0] HI_B7 = ADDR_W'(20'hB7FFF);
    localparam logic [ADDR_W-1:0] LO_B8 = ADDR_W'(20'hB8000);
    localparam logic [ADDR_W-1:0] HI_BF = ADDR_W'(20'hBFFFF);

    logic [15:0]      win_off;
    logic [OFF_W-1:0] banked;
    logic [OFF_W-1:0] scaled;
    logic [OFF_W-1:0] masked;

    always_comb begin
        case (map_sel)
            2'd1: begin
                hit     = (addr >= LO_A0) && (addr <= HI_AF);
                win_off = addr[15:0];
            end
            2'd2: begin
                hit     = (addr >= LO_B0) && (addr <= HI_B7);
                win_off = {1'b0, addr[14:0]};
            end
            2'd3: begin
                hit     = (addr >= LO_B8);
                win_off = {1'b0, addr[14:0]};
            end
            default: begin
                hit     = (addr >= LO_A0) && (addr <= HI_BF);
                win_off = addr[15:0];
            end
        endcase
        banked = OFF_W'(win_off[14:0]) + (win_off[15] ? bank1 : bank0);
        if (scale_x2)      scaled = banked << 1;
        else if (scale_x4) scaled = banked << 2;
        else               scaled = banked;
        masked    = scaled & mem_mask;
        byte_addr = masked << 2;
    end
endmodule

// File: rtl/vga_xrd_result.sv
module vga_xrd_result
    import vga_xrd_pkg::*;
(
    input  logic [LAT_W-1:0]  planes,
    input  logic              read_mode,
    input  logic [1:0]        map_pick,
    input  logic [PLANES-1:0] cmp_color,
    input  logic [PLANES-1:0] cmp_care,
    output logic [LANE_W-1:0] result
);
    logic [LANE_W-1:0] diff [PLANES];
    logic [LANE_W-1:0] any_diff;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        assign diff[p] = (planes[p*LANE_W +: LANE_W] ^ {LANE_W{cmp_color[p]}})
                         & {LANE_W{cmp_care[p]}};
    end

    always_comb begin
        any_diff = '0;
        for (int p = 0; p < PLANES; p++) any_diff = any_diff | diff[p];
        if (read_mode) result = ~any_diff;
        else           result = planes[map_pick*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/vga_ext_read.sv
module vga_ext_read
    import vga_xrd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_pix_vga,
    input  logic [4:1]             cfg_ext,
    input  logic [1:0]             cfg_map_sel,
    input  logic [OFF_W-1:0]       cfg_bank0,
    input  logic [OFF_W-1:0]       cfg_bank1,
    input  logic [OFF_W-1:0]       cfg_mem_mask,
    input  logic                   cfg_read_mode,
    input  logic [1:0]             cfg_map_pick,
    input  logic [PLANES-1:0]      cfg_cmp_color,
    input  logic [PLANES-1:0]      cfg_cmp_care,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   rsp_valid,
    output logic [LANE_W-1:0]      rsp_data,
    output logic                   mem_rd_en,
    output logic [OFF_W-1:0]       mem_rd_addr,
    input  logic [2*LAT_W-1:0]     mem_rd_data,
    output logic [LAT_W-1:0]       plane_latch,
    output logic [LAT_W-1:0]       ext_latch
);
    typedef struct packed {
        xrd_state_t         st;
        logic [OFF_W-1:0]   maddr;
        logic               rv;
        logic [LANE_W-1:0]  rd;
        logic [LAT_W-1:0]   pl;
        logic [LAT_W-1:0]   xl;
    } regs_t;

    regs_t r_q, r_d;

    logic              win_hit;
    logic [OFF_W-1:0]  win_byte_addr;
    logic [LANE_W-1:0] cmp_result;
    logic              path_on;
    logic              accept;

    vga_xrd_window #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_window (
        .addr      (req_addr),
        .map_sel   (cfg_map_sel),
        .bank0     (cfg_bank0),
        .bank1     (cfg_bank1),
        .scale_x2  (cfg_ext[1]),
        .scale_x4  (cfg_ext[4] & cfg_ext[2]),
        .mem_mask  (cfg_mem_mask),
        .hit       (win_hit),
        .byte_addr (win_byte_addr)
    );

    vga_xrd_result u_result (
        .planes    (mem_rd_data[LAT_W-1:0]),
        .read_mode (cfg_read_mode),
        .map_pick  (cfg_map_pick),
        .cmp_color (cfg_cmp_color),
        .cmp_care  (cfg_cmp_care),
        .result    (cmp_result)
    );

    always_comb begin
        path_on   = cfg_pix_vga && (cfg_ext != '0);
        req_ready = path_on && (r_q.st == ST_IDLE);
        accept    = req_valid && req_ready;
        r_d       = r_q;
        r_d.rv    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (win_hit) begin
                        r_d.st    = ST_ISSUE;
                        r_d.maddr = win_byte_addr;
                    end else begin
                        r_d.rv = 1'b1;
                        r_d.rd = '1;
                    end
                end
            end
            ST_ISSUE: r_d.st = ST_CAPTURE;
            ST_CAPTURE: begin
                r_d.pl = mem_rd_data[LAT_W-1:0];
                if (cfg_ext[3]) r_d.xl = mem_rd_data[2*LAT_W-1:LAT_W];
                r_d.rv = 1'b1;
                r_d.rd = cmp_result;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, maddr: '0, rv: 1'b0, rd: '0, pl: '0, xl: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid   = r_q.rv;
    assign rsp_data    = r_q.rd;
    assign mem_rd_en   = (r_q.st == ST_ISSUE);
    assign mem_rd_addr = r_q.maddr;
    assign plane_latch = r_q.pl;
    assign ext_latch   = r_q.xl;

    // R10: a memory strobe follows an accepted request and blocks new ones
    a_r10_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ($past(req_valid && req_ready) && !req_ready));

    // R3: a miss answers 0xFF next cycle without touching memory
    a_r3_miss_answers_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !win_hit) |=> (rsp_valid && rsp_data == 8'hFF && !mem_rd_en));

    // R6: plane latches move only two cycles after a memory strobe
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_rd_en, 2) |-> $stable(plane_latch));

    // R7: extended latches hold when the extended-latch control was off
    a_r7_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_ext[3]) |-> $stable(ext_latch));

    // R10: the response comes two cycles after the strobe, or after a miss
    a_r10_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(mem_rd_en, 2) || $past(req_valid && req_ready)));
endmodule

// File: tb/vga_ext_read_tb.sv
module vga_ext_read_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pix_vga = 1'b1;
    logic [4:1]  cfg_ext = 4'b0100;
    logic [1:0]  cfg_map_sel = 2'd0;
    logic [31:0] cfg_bank0 = '0, cfg_bank1 = '0, cfg_mem_mask = 32'h000F_FFFF;
    logic        cfg_read_mode = 1'b0;
    logic [1:0]  cfg_map_pick = 2'd0;
    logic [3:0]  cfg_cmp_color = '0, cfg_cmp_care = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [63:0] mem_rd_data = '0;
    logic [31:0] plane_latch, ext_latch;

    logic [31:0] m_plane = '0, m_ext = '0;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    vga_ext_read u_dut (.*);

    function automatic logic [7:0] memb(input logic [31:0] a);
        logic [31:0] h = a * 32'd2654435761;
        return h[20:13] ^ a[7:0];
    endfunction

    always @(posedge clk)
        if (mem_rd_en)
            for (int k = 0; k < 8; k++) mem_rd_data[8*k +: 8] <= memb(mem_rd_addr + 32'(k));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_addr(input logic [19:0] a, output bit hit, output logic [31:0] ba);
        longint unsigned ad = a, off, b, o;
        int f;
        case (cfg_map_sel)
            2'd1: begin hit = ad >= 'hA0000 && ad < 'hB0000; off = ad % 65536; end
            2'd2: begin hit = ad >= 'hB0000 && ad < 'hB8000; off = ad % 32768; end
            2'd3: begin hit = ad >= 'hB8000;                 off = ad % 32768; end
            default: begin hit = ad >= 'hA0000 && ad < 'hC0000; off = ad % 65536; end
        endcase
        b = (off >= 32768) ? cfg_bank1 : cfg_bank0;
        o = ((off % 32768) + b) % 64'h1_0000_0000;
        f = cfg_ext[1] ? 2 : ((cfg_ext[4] && cfg_ext[2]) ? 4 : 1);
        o = ((o * f) % 64'h1_0000_0000) & cfg_mem_mask;
        ba = 32'((o * 4) % 64'h1_0000_0000);
    endfunction

    function automatic logic [7:0] model_rsp(input logic [31:0] pl);
        logic [7:0] acc = '0;
        if (!cfg_read_mode) return pl[8*cfg_map_pick +: 8];
        for (int p = 0; p < 4; p++)
            acc |= (pl[8*p +: 8] ^ (cfg_cmp_color[p] ? 8'hFF : 8'h00)) & (cfg_cmp_care[p] ? 8'hFF : 8'h00);
        return ~acc;
    endfunction

    task automatic do_read(input logic [19:0] a, input string tag);
        bit hit, saw_mem = 0, saw_rsp = 0;
        logic [31:0] ea, got_addr = '0, ep = '0, ex = '0;
        logic [7:0] got = '0, er;
        model_addr(a, hit, ea);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R1 ready when idle"}, req_ready, 1);
        req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4 && !saw_rsp; i++) begin
            if (mem_rd_en) begin saw_mem = 1; got_addr = mem_rd_addr; end
            if (rsp_valid) begin saw_rsp = 1; got = rsp_data; end
            else begin
                if (saw_mem) chk(req_ready == 1'b0, {tag, " R10 ready low in flight"}, req_ready, 0);
                @(negedge clk);
            end
        end
        if (hit) begin
            for (int k = 0; k < 4; k++) begin
                ep[8*k +: 8] = memb(ea + 32'(k));
                ex[8*k +: 8] = memb(ea + 32'(k + 4));
            end
            m_plane = ep;
            if (cfg_ext[3]) m_ext = ex;
            er = model_rsp(ep);
            chk(saw_mem && got_addr == ea, {tag, " R4 R5 mem address"}, got_addr, ea);
            chk(saw_rsp && got == er, {tag, " R8 R9 rsp data"}, got, er);
        end else begin
            chk(!saw_mem, {tag, " R3 no memory read on miss"}, saw_mem, 0);
            chk(saw_rsp && got == 8'hFF, {tag, " R3 R2 miss data"}, got, 8'hFF);
        end
        chk(plane_latch == m_plane, {tag, " R6 plane latches"}, plane_latch, m_plane);
        chk(ext_latch == m_ext, {tag, " R7 ext latches"}, ext_latch, m_ext);
        @(negedge clk);
        chk(rsp_valid == 1'b0, {tag, " R10 single-cycle rsp"}, rsp_valid, 0);
    endtask

    task automatic inactive_try(input string tag);
        bit bad_mem = 0, bad_rsp = 0, bad_rdy = 0;
        logic [31:0] pl0 = plane_latch, xl0 = ext_latch;
        @(negedge clk);
        req_addr = 20'hA0010; req_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (mem_rd_en) bad_mem = 1;
            if (rsp_valid) bad_rsp = 1;
            if (req_ready) bad_rdy = 1;
        end
        req_valid = 1'b0;
        chk(!bad_rdy, {tag, " R1 ready low"}, bad_rdy, 0);
        chk(!bad_mem && !bad_rsp, {tag, " R1 no access"}, {bad_mem, bad_rsp}, 0);
        chk(plane_latch == pl0 && ext_latch == xl0, {tag, " R1 latches kept"}, plane_latch, pl0);
    endtask

    initial begin
        void'($urandom(32'd20240921));
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0 && mem_rd_en == 0, "R11 reset outputs", {rsp_valid, mem_rd_en}, 0);
        chk(plane_latch == 0 && ext_latch == 0, "R11 reset latches", plane_latch, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);

        // R1: path off
        cfg_pix_vga = 1'b0; cfg_ext = 4'b0001; inactive_try("pix_off");
        cfg_pix_vga = 1'b1; cfg_ext = 4'b0000; inactive_try("ext_zero");

        // R2 window edges and R3 misses
        cfg_ext = 4'b0100; cfg_mem_mask = 32'hFFFF_FFFF;
        cfg_bank0 = 32'h100; cfg_bank1 = 32'h9000;
        cfg_map_sel = 2'd1; do_read(20'hB0000, "sel1_miss"); do_read(20'hAFFFF, "sel1_top");
        cfg_map_sel = 2'd2; do_read(20'hB8000, "sel2_miss"); do_read(20'hB7FFF, "sel2_top");
        cfg_map_sel = 2'd3; do_read(20'hAFFFF, "sel3_miss"); do_read(20'hFFFFF, "sel3_top");
        cfg_map_sel = 2'd0; do_read(20'hC0000, "sel0_miss"); do_read(20'hA0000, "sel0_low");
        do_read(20'hA8004, "R4_bank1");

        // R5 scaling, priority and wrap
        cfg_ext = 4'b0001; do_read(20'hA0123, "R5_x2");
        cfg_ext = 4'b1010; do_read(20'hA0123, "R5_x4");
        cfg_ext = 4'b1011; do_read(20'hA0123, "R5_x2_wins");
        cfg_ext = 4'b0100; cfg_mem_mask = 32'h3FFF; cfg_bank0 = 32'h3FF0;
        do_read(20'hA0020, "R5_wrap");
        chk(m_plane == {memb(32'h43), memb(32'h42), memb(32'h41), memb(32'h40)},
            "R5 wrapped latch source", m_plane, 0);

        // R7 ext latch off keeps old value
        cfg_ext = 4'b0001; do_read(20'hA0300, "R7_ext_off");

        // R9 compare
        cfg_read_mode = 1'b1; cfg_cmp_color = 4'b1010; cfg_cmp_care = 4'b0000;
        do_read(20'hA0400, "R9_no_care");
        cfg_cmp_care = 4'b1111; do_read(20'hA0401, "R9_all_care");
        cfg_read_mode = 1'b0;

        for (int n = 0; n < 300; n++) begin
            logic [4:1] e = 4'($urandom);
            if (e == 0) e = 4'b0100;
            cfg_ext = e;
            cfg_map_sel = 2'($urandom);
            cfg_mem_mask = (32'h1 << (10 + $urandom % 15)) - 1;
            cfg_bank0 = ($urandom % 4 == 0) ? (32'hFFFF_F000 | 32'($urandom % 4096)) : $urandom % 32'h20000;
            cfg_bank1 = $urandom % 32'h40000;
            cfg_read_mode = 1'($urandom);
            cfg_map_pick = 2'($urandom);
            cfg_cmp_color = 4'($urandom);
            cfg_cmp_care = 4'($urandom);
            do_read(($urandom % 8 == 0) ? 20'($urandom) : 20'hA0000 + 20'($urandom % 32'h20000), "rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule